// File: doc/BRIEF.md
# Burst Cycle Clock Inserter

This block produces the CPU clock from a fast reference clock that ticks sixteen times per slow system bus cycle. Most of the time the CPU clock simply follows the bus cycle: one CPU cycle per bus cycle. When the CPU cycle that comes next is known not to need the memory bus, the block cuts the current high phase short. It then fits one complete short CPU cycle into the tail of the same bus cycle. The CPU thus completes two operations in a single bus cycle, and the bus side only ever sees its usual one access.

A one-byte read cache widens the set of cycles that can be compressed. Every CPU memory read leaves its address and data in the cache. A later read of the cached address is served from the cache during a burst cycle, with the block driving the CPU data bus. A CPU write to the cached address, or a reset, empties the cache. The look-ahead information (whether the next cycle is internal, and whether and where it reads) is supplied by the surrounding logic; instruction decoding is not part of this block.

Tick numbering: a tick is one reference clock period. Tick 0 is the first tick after `bus_sync` was sampled high, or after reset. Ticks count up and wrap from 15 to 0. The burst decision is taken at the reference clock edge that ends tick 8.

Top module: `burst_clock_inserter`

## Requirements
- R1: While `rst_n` is low, and in the first tick after it is released, `cpu_clk` and `data_oe` are 0.
- R2: When `bus_sync` is sampled high at an edge, the following tick is tick 0, whatever the current tick count was; without it the count wraps from 15 to 0.
- R3: In a bus cycle without a burst, `cpu_clk` is 0 during ticks 0 to 6 and 1 during ticks 7 to 15.
- R4: If `next_internal` is 1 at the decision edge (end of tick 8), the bus cycle becomes a burst cycle.
- R5: In a burst cycle, `cpu_clk` is 1 in ticks 7-8, 0 in the gap tick 9, 1 in the fast ticks 10-11, and 0 in ticks 12-15 (fast low 12-13, settle 14, then low until the normal high phase of the next cycle), which gives two falling edges in one bus cycle.
- R6: A `next_internal` that first rises during tick 9 or later has no effect on the current bus cycle, which keeps the normal shape.
- R7: When `cpu_rd` is 1 at the decision edge, `cpu_addr` and `mem_data` are stored in the cache and replace any earlier entry.
- R8: When `next_rd` is 1 at the decision edge and `next_addr` equals the cached address (including a read stored at that same edge), the cycle is a burst, and `data_oe` is 1 in ticks 9 to 12 with `data_out` equal to the cached byte.
- R9: A `next_rd` whose address is not cached, with `next_internal` at 0, gives a normal cycle with `data_oe` at 0.
- R10: `cpu_wr` at the decision edge to the cached address empties the cache; a write to any other address leaves it intact.
- R11: A burst granted through `next_internal` alone, with no cache hit, keeps `data_oe` at 0.
- R12: Reset empties the cache, so a read of a previously cached address gives no burst after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock, 16 ticks per bus cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sync | input | 1 | Bus cycle alignment; the next tick is tick 0 |
| next_internal | input | 1 | Next CPU cycle does not use memory |
| next_rd | input | 1 | Next CPU cycle is a memory read |
| next_addr | input | 16 | Address of the next CPU cycle's read |
| cpu_rd | input | 1 | Current bus cycle is a CPU read |
| cpu_wr | input | 1 | Current bus cycle is a CPU write |
| cpu_addr | input | 16 | Address of the current bus access |
| mem_data | input | 8 | Memory data of the current read |
| cpu_clk | output | 1 | Clock phase delivered to the CPU |
| data_oe | output | 1 | Enable for driving the CPU data bus from the cache |
| data_out | output | 8 | Cached byte |

## Verification
On every cycle, the assertions check the local shape of the outputs. A realignment always yields a low clock and an idle data drive. Every high phase lasts at least two ticks. The cache drive starts just after a clock fall, lasts exactly four ticks, keeps its byte stable, and ends with the clock low. Whether a particular cycle should have been compressed depends on the look-ahead inputs, the cache contents and the arrival tick of the flag. The full sixteen-tick waveform, the fill and invalidation rules, late flags, realignment and the cache clear on reset are therefore shown by the bench's scenarios, which compare each bus cycle with a waveform computed from the requirements.

// File: rtl/bci_pkg.sv
// Package: shared types of the burst cycle clock inserter.
// Assumes: nothing beyond SystemVerilog 2017.
package bci_pkg;

    // Segment of the bus cycle that the CPU clock is currently in.
    typedef enum logic [2:0] {
        SEG_LOW,
        SEG_NORM_HI,
        SEG_GAP,
        SEG_FAST_HI,
        SEG_FAST_LO,
        SEG_SETTLE
    } clk_seg_e;

endpackage

// File: rtl/bci_phase.sv
// Module: bci_phase
// Counts reference ticks within one bus cycle. A bus_sync sampled high
// makes the next tick number 0; otherwise the count wraps at CYC_TICKS.
// Assumes: CYC_TICKS is a power of two or at least fits PW bits.
module bci_phase #(
    parameter int CYC_TICKS = 16,
    localparam int PW = $clog2(CYC_TICKS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_sync,
    output logic [PW-1:0] phase
);

    localparam logic [PW-1:0] LAST_P = PW'(CYC_TICKS - 1);

    // Advance the tick count, realigning on bus_sync.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= '0;
        end else if (bus_sync || phase == LAST_P) begin
            phase <= '0;
        end else begin
            phase <= phase + 1'b1;
        end
    end

endmodule

// File: rtl/bci_cache.sv
// Module: bci_cache
// One-entry read cache. On the capture strobe a CPU read stores its
// address and data; a CPU write to the held address empties the entry.
// The hit output compares the look-ahead read against the entry as it
// will be after the capture, so a read followed by the same read hits.
// Assumes: capture is a one-tick strobe at the burst decision tick.
module bci_cache #(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          capture,
    input  logic          cpu_rd,
    input  logic          cpu_wr,
    input  logic [AW-1:0] cpu_addr,
    input  logic [DW-1:0] mem_data,
    input  logic          next_rd,
    input  logic [AW-1:0] next_addr,
    output logic          hit,
    output logic [DW-1:0] line_data
);

    logic          vld_q;
    logic [AW-1:0] tag_q;
    logic [DW-1:0] dat_q;
    logic          vld_v;
    logic [AW-1:0] tag_v;
    logic [DW-1:0] dat_v;

    // Entry contents as they stand after this tick's access is applied.
    always_comb begin
        vld_v = vld_q;
        tag_v = tag_q;
        dat_v = dat_q;
        if (cpu_rd) begin
            vld_v = 1'b1;
            tag_v = cpu_addr;
            dat_v = mem_data;
        end else if (cpu_wr && cpu_addr == tag_q) begin
            vld_v = 1'b0;
        end
    end

    // Look-ahead read matches the entry.
    assign hit       = next_rd && vld_v && (next_addr == tag_v);
    assign line_data = dat_q;

    // Commit the entry at the decision strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= 1'b0;
            tag_q <= '0;
            dat_q <= '0;
        end else if (capture) begin
            vld_q <= vld_v;
            tag_q <= tag_v;
            dat_q <= dat_v;
        end
    end

endmodule

// File: rtl/bci_shaper.sv
// Module: bci_shaper
// Takes the burst decision at the end of the decision tick and shapes
// the CPU clock phase and the cache drive enable from the tick count.
// Assumes: HI_START < BURST_TICK - 1 and the burst ends by the last tick.
module bci_shaper
    import bci_pkg::*;
#(
    parameter int CYC_TICKS  = 16,
    parameter int HI_START   = 7,
    parameter int BURST_TICK = 10,
    parameter int FAST_HI    = 2,
    parameter int FAST_LO    = 2,
    parameter int SETTLE     = 1,
    localparam int PW = $clog2(CYC_TICKS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_sync,
    input  logic [PW-1:0] phase,
    input  logic          eligible,
    input  logic          hit,
    output logic          decide,
    output logic          cpu_clk,
    output logic          data_oe
);

    localparam logic [PW-1:0] HI_P     = PW'(HI_START);
    localparam logic [PW-1:0] DECIDE_P = PW'(BURST_TICK - 2);
    localparam logic [PW-1:0] GAP_P    = PW'(BURST_TICK - 1);
    localparam logic [PW-1:0] FH_END_P = PW'(BURST_TICK + FAST_HI);
    localparam logic [PW-1:0] FL_END_P = PW'(BURST_TICK + FAST_HI + FAST_LO);
    localparam int            ST_END   = BURST_TICK + FAST_HI + FAST_LO + SETTLE;
    localparam logic [PW-1:0] LAST_P   = PW'(CYC_TICKS - 1);

    logic     burst_q;
    logic     hit_q;
    clk_seg_e seg;

    assign decide = (phase == DECIDE_P);

    // Hold the burst decision for the rest of the bus cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            burst_q <= 1'b0;
            hit_q   <= 1'b0;
        end else if (bus_sync || phase == LAST_P) begin
            burst_q <= 1'b0;
            hit_q   <= 1'b0;
        end else if (decide) begin
            burst_q <= eligible;
            hit_q   <= hit;
        end
    end

    // Classify the current tick into a clock segment.
    always_comb begin
        if (phase < HI_P) begin
            seg = SEG_LOW;
        end else if (!burst_q || phase < GAP_P) begin
            seg = SEG_NORM_HI;
        end else if (phase == GAP_P) begin
            seg = SEG_GAP;
        end else if (phase < FH_END_P) begin
            seg = SEG_FAST_HI;
        end else if (phase < FL_END_P) begin
            seg = SEG_FAST_LO;
        end else if (32'(phase) < ST_END) begin
            seg = SEG_SETTLE;
        end else begin
            seg = SEG_LOW;
        end
    end

    assign cpu_clk = (seg == SEG_NORM_HI) || (seg == SEG_FAST_HI);
    assign data_oe = burst_q && hit_q && (phase >= GAP_P) && (phase <= FH_END_P);

endmodule

// File: rtl/burst_clock_inserter.sv
// Module: burst_clock_inserter (top)
// Derives the CPU clock from a fast reference, inserting one short CPU
// cycle into the tail of a bus cycle when the next cycle is internal or
// re-reads the byte held in the one-entry read cache.
// Assumes: look-ahead and bus access inputs are stable at the decision tick.
module burst_clock_inserter #(
    parameter int CYC_TICKS  = 16,
    parameter int HI_START   = 7,
    parameter int BURST_TICK = 10,
    parameter int FAST_HI    = 2,
    parameter int FAST_LO    = 2,
    parameter int SETTLE     = 1,
    parameter int AW         = 16,
    parameter int DW         = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_sync,
    input  logic          next_internal,
    input  logic          next_rd,
    input  logic [AW-1:0] next_addr,
    input  logic          cpu_rd,
    input  logic          cpu_wr,
    input  logic [AW-1:0] cpu_addr,
    input  logic [DW-1:0] mem_data,
    output logic          cpu_clk,
    output logic          data_oe,
    output logic [DW-1:0] data_out
);

    localparam int PW = $clog2(CYC_TICKS);

    logic [PW-1:0] phase;
    logic          decide;
    logic          hit;

    bci_phase #(.CYC_TICKS(CYC_TICKS)) u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_sync (bus_sync),
        .phase    (phase)
    );

    bci_cache #(.AW(AW), .DW(DW)) u_cache (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture   (decide),
        .cpu_rd    (cpu_rd),
        .cpu_wr    (cpu_wr),
        .cpu_addr  (cpu_addr),
        .mem_data  (mem_data),
        .next_rd   (next_rd),
        .next_addr (next_addr),
        .hit       (hit),
        .line_data (data_out)
    );

    bci_shaper #(
        .CYC_TICKS  (CYC_TICKS),
        .HI_START   (HI_START),
        .BURST_TICK (BURST_TICK),
        .FAST_HI    (FAST_HI),
        .FAST_LO    (FAST_LO),
        .SETTLE     (SETTLE)
    ) u_shaper (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_sync (bus_sync),
        .phase    (phase),
        .eligible (next_internal || hit),
        .hit      (hit),
        .decide   (decide),
        .cpu_clk  (cpu_clk),
        .data_oe  (data_oe)
    );

endmodule

// File: rtl/bci_checker.sv
// Module: bci_checker
// Clocked properties on the outputs of burst_clock_inserter, attached
// through the bind statement at the end of this file.
// Assumes: default timing (four-tick cache drive window).
module bci_checker #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_sync,
    input logic          cpu_clk,
    input logic          data_oe,
    input logic [DW-1:0] data_out
);

    // Leaving reset starts with a low clock and no drive.
    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!cpu_clk && !data_oe));

    // Realignment lands in tick 0, which is low and undriven.
    p_sync_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_sync |=> (!cpu_clk && !data_oe));

    // Normal and fast high phases both last at least two ticks.
    p_high_min_r3_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_clk) |=> cpu_clk);

    // Cache drive starts right after a clock fall.
    p_oe_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(data_oe) |-> (!cpu_clk && $past(cpu_clk)));

    // Cache drive lasts exactly four ticks.
    p_oe_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(data_oe) |-> ($past(data_oe, 4) && !$past(data_oe, 5)));

    // Driven byte does not change inside the window.
    p_oe_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (data_oe && $past(data_oe)) |-> $stable(data_out));

    // Drive ends with the fast pulse already low.
    p_oe_end_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(data_oe) |-> !cpu_clk);

endmodule

bind burst_clock_inserter bci_checker #(.DW(DW)) u_bci_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_sync (bus_sync),
    .cpu_clk  (cpu_clk),
    .data_oe  (data_oe),
    .data_out (data_out)
);

// File: tb/tb_burst_clock_inserter.sv
// Bench for burst_clock_inserter: a vector table of whole bus cycles,
// then directed tests for late flags, realignment and reset.
module tb_burst_clock_inserter;

    typedef struct packed {
        logic        ni;
        logic        nrd;
        logic [15:0] naddr;
        logic        rd;
        logic        wr;
        logic [15:0] addr;
        logic [7:0]  md;
        logic        eb;
        logic        eoe;
        logic [7:0]  ed;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 16'h0000, 8'h00, 1'b0, 1'b0, 8'h00}, // R3 idle
        '{1'b1, 1'b0, 16'h0000, 1'b0, 1'b0, 16'h0000, 8'h00, 1'b1, 1'b0, 8'h00}, // R4 R11
        '{1'b0, 1'b1, 16'h1234, 1'b1, 1'b0, 16'h1234, 8'hA5, 1'b1, 1'b1, 8'hA5}, // R7 R8
        '{1'b0, 1'b1, 16'h1234, 1'b0, 1'b0, 16'h0000, 8'h00, 1'b1, 1'b1, 8'hA5}, // R8 held
        '{1'b0, 1'b1, 16'h1235, 1'b0, 1'b0, 16'h0000, 8'h00, 1'b0, 1'b0, 8'h00}, // R9
        '{1'b0, 1'b1, 16'h1234, 1'b1, 1'b0, 16'h2000, 8'h3C, 1'b0, 1'b0, 8'h00}, // R7 replace
        '{1'b0, 1'b1, 16'h2000, 1'b0, 1'b0, 16'h0000, 8'h00, 1'b1, 1'b1, 8'h3C}, // R8
        '{1'b0, 1'b1, 16'h2000, 1'b0, 1'b1, 16'h3000, 8'h00, 1'b1, 1'b1, 8'h3C}, // R10 other
        '{1'b0, 1'b1, 16'h2000, 1'b0, 1'b1, 16'h2000, 8'h00, 1'b0, 1'b0, 8'h00}, // R10 same
        '{1'b0, 1'b1, 16'h2000, 1'b0, 1'b0, 16'h0000, 8'h00, 1'b0, 1'b0, 8'h00}, // R10 empty
        '{1'b1, 1'b1, 16'h0055, 1'b1, 1'b0, 16'h0055, 8'h99, 1'b1, 1'b1, 8'h99}, // R8
        '{1'b1, 1'b1, 16'h0000, 1'b0, 1'b0, 16'h0000, 8'h00, 1'b1, 1'b0, 8'h00}  // R11
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sync = 1'b0;
    logic        next_internal = 1'b0;
    logic        next_rd = 1'b0;
    logic [15:0] next_addr = '0;
    logic        cpu_rd = 1'b0;
    logic        cpu_wr = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  mem_data = '0;
    logic        cpu_clk;
    logic        data_oe;
    logic [7:0]  data_out;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  done = 1'b0;

    always #5 clk = ~clk;

    burst_clock_inserter dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .bus_sync      (bus_sync),
        .next_internal (next_internal),
        .next_rd       (next_rd),
        .next_addr     (next_addr),
        .cpu_rd        (cpu_rd),
        .cpu_wr        (cpu_wr),
        .cpu_addr      (cpu_addr),
        .mem_data      (mem_data),
        .cpu_clk       (cpu_clk),
        .data_oe       (data_oe),
        .data_out      (data_out)
    );

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", what, act, exp);
        end
    endtask

    // Expected clock shape per tick: normal (R3) or burst (R5).
    function automatic logic [15:0] shape(input logic b);
        logic [15:0] s;
        for (int t = 0; t < 16; t++) begin
            if (b) s[t] = (t == 7 || t == 8 || t == 10 || t == 11);
            else   s[t] = (t >= 7);
        end
        return s;
    endfunction

    // Run one bus cycle starting at a negedge in tick 0.
    task automatic run_cycle(input vec_t v, input bit late, input string tag);
        logic [15:0] clk_pat;
        logic [15:0] oe_pat;
        logic [15:0] oe_exp;
        logic [7:0]  dval;
        next_rd   = v.nrd;
        next_addr = v.naddr;
        cpu_rd    = v.rd;
        cpu_wr    = v.wr;
        cpu_addr  = v.addr;
        mem_data  = v.md;
        dval      = 8'h00;
        for (int t = 0; t < 16; t++) begin
            next_internal = late ? (t >= 9) : v.ni;
            bus_sync = (t == 15);
            clk_pat[t] = cpu_clk;
            oe_pat[t]  = data_oe;
            if (t == 10) dval = data_out;
            @(posedge clk);
            @(negedge clk);
        end
        bus_sync = 1'b0;
        for (int t = 0; t < 16; t++) oe_exp[t] = v.eoe && (t >= 9 && t <= 12);
        chk({tag, " clock shape"}, 32'(clk_pat), 32'(shape(v.eb)));
        chk({tag, " drive window"}, 32'(oe_pat), 32'(oe_exp));
        if (v.eoe) chk({tag, " driven byte"}, 32'(dval), 32'(v.ed));
    endtask

    initial begin
        vec_t nv;
        // R1: quiet outputs during reset
        repeat (3) @(negedge clk);
        chk("R1 clk in reset", 32'(cpu_clk), 32'h0);
        chk("R1 oe in reset", 32'(data_oe), 32'h0);
        rst_n = 1'b1;
        chk("R1 clk after release", 32'(cpu_clk), 32'h0);

        // Vector table walk: R3 R4 R5 R7 R8 R9 R10 R11
        for (int i = 0; i < NV; i++) begin
            run_cycle(VEC[i], 1'b0, $sformatf("vector %0d (R3 R4 R5 R7 R8 R9 R10 R11)", i));
        end

        // R6: flag raised in tick 9 is too late
        nv = '0;
        nv.ni = 1'b1;
        nv.eb = 1'b0;
        run_cycle(nv, 1'b1, "R6 late flag");
        next_internal = 1'b0;

        // R2: realign mid-cycle; clock stays low in ticks 0..5
        begin
            logic [5:0] part;
            for (int t = 0; t < 6; t++) begin
                bus_sync = (t == 5);
                part[t] = cpu_clk;
                @(posedge clk);
                @(negedge clk);
            end
            bus_sync = 1'b0;
            chk("R2 low before realign", 32'(part), 32'h0);
            chk("R2 tick 0 after realign", 32'(cpu_clk), 32'h0);
        end
        nv = '0;
        nv.ni = 1'b1;
        nv.eb = 1'b1;
        run_cycle(nv, 1'b0, "R2 R5 burst after realign");

        // R12: reset in the middle of use, then cached address misses
        nv = '0;
        nv.rd = 1'b1;
        nv.addr = 16'h0077;
        nv.md = 8'h42;
        nv.nrd = 1'b1;
        nv.naddr = 16'h0077;
        nv.eb = 1'b1;
        nv.eoe = 1'b1;
        nv.ed = 8'h42;
        run_cycle(nv, 1'b0, "R12 fill before reset (R8)");
        rst_n = 1'b0;
        cpu_rd = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 clk in second reset", 32'(cpu_clk), 32'h0);
        chk("R1 oe in second reset", 32'(data_oe), 32'h0);
        rst_n = 1'b1;
        nv = '0;
        nv.nrd = 1'b1;
        nv.naddr = 16'h0077;
        run_cycle(nv, 1'b0, "R12 cache empty after reset");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule